// File: doc/BRIEF.md
# I2C Master Register Front-End

This block is the software-facing half of an I2C master. A host reaches it through a small byte-wide register port with five registers: the controller's own slave address, a clock divider, a control register, a status register and a data register. Register traffic is translated into byte-level commands for a separate bus engine, which handles SCL/SDA timing. The commands are start-with-address, write byte, read byte and stop. The engine answers each command with a one-cycle done pulse, an acknowledge flag and, for reads, the received byte. One level-sensitive interrupt line reports completed transfers.

The first data-register write after the bus is claimed becomes the address byte. Later writes are payload bytes. Reading the data register returns the byte held from the previous fetch and, in receive mode, starts fetching the next byte, so that byte is ready for the read after it.

A command sequencer sits behind the registers and has five states:
- IDLE: no command outstanding.
- ADDR: start plus address byte.
- TX: payload write.
- RX: payload read.
- STOP: release the bus.

The sequencer takes these transitions:
- IDLE goes to ADDR when an address phase begins.
- IDLE goes to TX when a payload write is made.
- IDLE goes to RX when a receive fetch is made.
- IDLE goes to STOP when an open transfer is ended.
- ADDR or TX goes to STOP when the engine reports done with a NACK, or when an end was requested during the command.
- RX goes to STOP when an end was requested during the fetch.
- ADDR, TX or RX goes back to IDLE when the engine reports done and no stop is needed.
- STOP goes to IDLE when the engine reports done.

Top module: `i2c_master_regfront`

## Requirements
- R1: Offsets are own address = 0, divider = 1, control = 2, status = 3, data = 4. The own-address register keeps bits 7:1 and reads bit 0 as 0. The divider keeps bits 5:0. Control keeps bits 7 (enable), 6 (interrupt enable), 5 (master select), 4 (transmit select) and 2 (repeated start); its other bits read 0. Offsets 5 to 7 read 0x00, and writes to them change nothing.
- R2: A control write that clears bit 7 while bit 7 is set is a soft reset. Divider, control, status and held receive byte return to 0x00, the own address is kept, and an open transfer is ended with a STOP command.
- R3: Every normal control write copies the master-select bit into status bit 5 (bus busy). Clearing master select while a transfer is open issues a STOP command.
- R4: Writing control with bit 2 set while a transfer is open issues a STOP command and stores bit 2 as 0. The next data write is then an address phase.
- R5: A data write while enabled, in master mode, with no transfer open and no command outstanding, issues a START command (op code 0) carrying the written byte. Bits 7:1 of that byte are the target address and bit 0 is the direction. Later data writes on an open transfer issue WRITE commands (op code 1).
- R6: When the engine acknowledges an address or payload byte, status bit 0 (received NACK) is cleared and an interrupt is requested. When it does not acknowledge, bit 0 is set, the transfer is closed and a STOP command (op code 3) follows.
- R7: Data writes have no effect while control bit 7 is clear.
- R8: In master mode with no command outstanding, a data read returns the held byte. With a transfer open and transmit select clear, the read also issues a READ command (op code 2); the byte returned by the engine becomes the held byte and an interrupt is requested. Otherwise the held byte becomes 0xFF.
- R9: An interrupt request sets status bit 1 (interrupt flag) only when control bits 7 and 6 are both set. The irq output follows status bit 1.
- R10: Status bits 1 and 4 are each cleared by writing 0 to that bit while it is set. Writing 1 leaves them unchanged. Clearing bit 1 drops irq.
- R11: Commands use a valid/done handshake. cmd_valid, cmd_op and cmd_byte are held steady until cmd_done. Only one command is outstanding at a time, and data-register accesses made while one is outstanding have no effect.
- R12: div_o presents the divider register unchanged and changes only after a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data reads have side effects) |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the offset |
| cmd_valid | output | 1 | Command to bus engine is pending |
| cmd_op | output | 2 | Command code: 0 start, 1 write, 2 read, 3 stop |
| cmd_byte | output | 8 | Address or payload byte for start and write |
| cmd_done | input | 1 | One-cycle completion pulse from the engine |
| cmd_nack | input | 1 | Target did not acknowledge (valid with done) |
| rx_byte | input | 8 | Received byte (valid with done of a read) |
| div_o | output | DIV_W | Clock divider setting for the engine |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A NACK on a payload byte. A design that kept the transfer open would issue a WRITE instead of a START for the next data write, and it would omit the STOP.
- A second data write while a command is still outstanding. A design that accepted it would emit an extra command, which the scoreboard flags as unexpected.
- The receive pipeline. A design that returned the freshly fetched byte on the same read, or that skipped the 0xFF fill when transmit select is set, returns the wrong value.
- Soft reset. A design that cleared the own address, or that left the held byte or the divider intact, fails the read-back.
- Interrupt gating. A design that set the flag with interrupt enable off would raise irq.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int BYTE_W = 8;

    // register offsets
    localparam int OFS_OWN  = 0;
    localparam int OFS_DIV  = 1;
    localparam int OFS_CTRL = 2;
    localparam int OFS_STAT = 3;
    localparam int OFS_DATA = 4;

    // control bit positions
    localparam int CB_EN   = 7;
    localparam int CB_IEN  = 6;
    localparam int CB_MST  = 5;
    localparam int CB_TX   = 4;
    localparam int CB_RSTA = 2;

    // status bit positions
    localparam int SB_BUSY = 5;
    localparam int SB_ARB  = 4;
    localparam int SB_IIF  = 1;
    localparam int SB_RXAK = 0;

    localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'hF4;
    localparam logic [BYTE_W-1:0] OWN_KEEP  = 8'hFE;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } rf_op_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_TX   = 3'd2,
        S_RX   = 3'd3,
        S_STOP = 3'd4
    } seq_state_e;

endpackage

// File: rtl/i2c_rf_seq.sv
module i2c_rf_seq
    import i2c_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_start,
    input  logic              launch_tx,
    input  logic              launch_rx,
    input  logic              req_stop,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              cmd_done,
    input  logic              cmd_nack,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              seq_idle,
    output logic              xfer_live,
    output logic              ev_ack,
    output logic              ev_nack,
    output logic              ev_rx
);

    seq_state_e        st_q, st_nxt;
    logic              open_q;
    logic              stop_pend_q;
    logic [BYTE_W-1:0] byte_q;
    logic              in_data_cmd;

    assign in_data_cmd = (st_q == S_ADDR) || (st_q == S_TX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // next-state decode
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (launch_start)      st_nxt = S_ADDR;
                else if (launch_tx)    st_nxt = S_TX;
                else if (launch_rx)    st_nxt = S_RX;
                else if (req_stop)     st_nxt = S_STOP;
            end
            S_ADDR, S_TX: begin
                if (cmd_done)
                    st_nxt = (cmd_nack || stop_pend_q || req_stop) ? S_STOP : S_IDLE;
            end
            S_RX: begin
                if (cmd_done)
                    st_nxt = (stop_pend_q || req_stop) ? S_STOP : S_IDLE;
            end
            S_STOP: begin
                if (cmd_done) st_nxt = S_IDLE;
            end
            default: st_nxt = S_IDLE;
        endcase
    end

    // command outputs
    always_comb begin
        cmd_valid = 1'b1;
        cmd_op    = OP_STOP;
        cmd_byte  = '0;
        unique case (st_q)
            S_IDLE: cmd_valid = 1'b0;
            S_ADDR: begin
                cmd_op   = OP_START;
                cmd_byte = byte_q;
            end
            S_TX: begin
                cmd_op   = OP_WRITE;
                cmd_byte = byte_q;
            end
            S_RX:   cmd_op = OP_READ;
            S_STOP: cmd_op = OP_STOP;
            default: cmd_valid = 1'b0;
        endcase
    end

    // transfer bookkeeping: open flag, deferred stop, latched byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q      <= 1'b0;
            stop_pend_q <= 1'b0;
            byte_q      <= '0;
        end else begin
            if (st_q == S_IDLE && (launch_start || launch_tx))
                byte_q <= tx_byte;

            if (req_stop)
                open_q <= 1'b0;
            else if (st_q == S_ADDR && cmd_done && !cmd_nack && !stop_pend_q)
                open_q <= 1'b1;
            else if (st_q == S_TX && cmd_done && cmd_nack)
                open_q <= 1'b0;

            if (st_nxt == S_STOP)
                stop_pend_q <= 1'b0;
            else if (req_stop && st_q != S_IDLE)
                stop_pend_q <= 1'b1;
        end
    end

    assign seq_idle  = (st_q == S_IDLE);
    assign xfer_live = open_q || in_data_cmd || (st_q == S_RX);
    assign ev_ack    = cmd_done && !cmd_nack && in_data_cmd;
    assign ev_nack   = cmd_done &&  cmd_nack && in_data_cmd;
    assign ev_rx     = cmd_done && (st_q == S_RX);

endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
    import i2c_rf_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [DIV_W-1:0]  div_o,
    output logic              irq,
    input  logic              seq_idle,
    input  logic              xfer_live,
    input  logic              ev_ack,
    input  logic              ev_nack,
    input  logic              ev_rx,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              launch_start,
    output logic              launch_tx,
    output logic              launch_rx,
    output logic              req_stop,
    output logic [BYTE_W-1:0] tx_byte
);

    logic [BYTE_W-1:0] own_q, ctrl_q, stat_q, held_q;
    logic [DIV_W-1:0]  div_q;

    logic hit_own, hit_div, hit_ctrl, hit_stat, hit_data;
    logic soft_rst, ctrl_norm, data_wr_ok, data_rd_mst, fill_held, irq_req;
    logic [BYTE_W-1:0] ctrl_new;

    assign hit_own  = (reg_addr == ADDR_W'(OFS_OWN));
    assign hit_div  = (reg_addr == ADDR_W'(OFS_DIV));
    assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
    assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
    assign hit_data = (reg_addr == ADDR_W'(OFS_DATA));

    assign ctrl_new  = reg_wdata & CTRL_KEEP;
    assign soft_rst  = reg_wr && hit_ctrl && ctrl_q[CB_EN] && !reg_wdata[CB_EN];
    assign ctrl_norm = reg_wr && hit_ctrl && !soft_rst;

    // data register actions
    assign data_wr_ok   = reg_wr && hit_data && ctrl_q[CB_EN] && ctrl_q[CB_MST] && seq_idle;
    assign launch_start = data_wr_ok && !xfer_live;
    assign launch_tx    = data_wr_ok &&  xfer_live;
    assign tx_byte      = reg_wdata;
    assign data_rd_mst  = reg_rd && hit_data && ctrl_q[CB_MST] && seq_idle;
    assign launch_rx    = data_rd_mst && xfer_live && !ctrl_q[CB_TX];
    assign fill_held    = data_rd_mst && !launch_rx;

    // end of an open transfer: soft reset, master drop or repeated start
    assign req_stop = xfer_live &&
                      (soft_rst || (ctrl_norm && (!ctrl_new[CB_MST] || ctrl_new[CB_RSTA])));

    assign irq_req = (ev_ack || ev_rx) && ctrl_q[CB_EN] && ctrl_q[CB_IEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q  <= '0;
            div_q  <= '0;
            ctrl_q <= '0;
            stat_q <= '0;
            held_q <= '0;
        end else begin
            if (reg_wr && hit_own)
                own_q <= reg_wdata & OWN_KEEP;
            if (reg_wr && hit_div)
                div_q <= reg_wdata[DIV_W-1:0];
            if (soft_rst) begin
                div_q  <= '0;
                ctrl_q <= '0;
                stat_q <= '0;
                held_q <= '0;
            end
            if (ctrl_norm) begin
                ctrl_q          <= ctrl_new;
                ctrl_q[CB_RSTA] <= ctrl_new[CB_RSTA] && !xfer_live;
                stat_q[SB_BUSY] <= ctrl_new[CB_MST];
            end
            if (reg_wr && hit_stat) begin
                if (stat_q[SB_IIF] && !reg_wdata[SB_IIF]) stat_q[SB_IIF] <= 1'b0;
                if (stat_q[SB_ARB] && !reg_wdata[SB_ARB]) stat_q[SB_ARB] <= 1'b0;
            end
            if (fill_held)
                held_q <= FILL_BYTE;
            if (ev_ack)
                stat_q[SB_RXAK] <= 1'b0;
            if (ev_nack)
                stat_q[SB_RXAK] <= 1'b1;
            if (ev_rx)
                held_q <= rx_byte;
            if (irq_req)
                stat_q[SB_IIF] <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_own)       reg_rdata = own_q;
        else if (hit_div)  reg_rdata = BYTE_W'(div_q);
        else if (hit_ctrl) reg_rdata = ctrl_q;
        else if (hit_stat) reg_rdata = stat_q;
        else if (hit_data) reg_rdata = held_q;
    end

    assign div_o = div_q;
    assign irq   = stat_q[SB_IIF];

endmodule

// File: rtl/i2c_master_regfront.sv
module i2c_master_regfront
    import i2c_rf_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_byte,
    input  logic              cmd_done,
    input  logic              cmd_nack,
    input  logic [7:0]        rx_byte,
    output logic [DIV_W-1:0]  div_o,
    output logic              irq
);

    logic              seq_idle, xfer_live;
    logic              ev_ack, ev_nack, ev_rx;
    logic              launch_start, launch_tx, launch_rx, req_stop;
    logic [BYTE_W-1:0] tx_byte;

    i2c_rf_regs #(
        .ADDR_W(ADDR_W),
        .DIV_W (DIV_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .div_o       (div_o),
        .irq         (irq),
        .seq_idle    (seq_idle),
        .xfer_live   (xfer_live),
        .ev_ack      (ev_ack),
        .ev_nack     (ev_nack),
        .ev_rx       (ev_rx),
        .rx_byte     (rx_byte),
        .launch_start(launch_start),
        .launch_tx   (launch_tx),
        .launch_rx   (launch_rx),
        .req_stop    (req_stop),
        .tx_byte     (tx_byte)
    );

    i2c_rf_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_start(launch_start),
        .launch_tx   (launch_tx),
        .launch_rx   (launch_rx),
        .req_stop    (req_stop),
        .tx_byte     (tx_byte),
        .cmd_done    (cmd_done),
        .cmd_nack    (cmd_nack),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_byte    (cmd_byte),
        .seq_idle    (seq_idle),
        .xfer_live   (xfer_live),
        .ev_ack      (ev_ack),
        .ev_nack     (ev_nack),
        .ev_rx       (ev_rx)
    );

endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk #(
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [7:0]       cmd_byte,
    input logic             cmd_done,
    input logic             cmd_nack,
    input logic             irq,
    input logic [DIV_W-1:0] div_o
);

    // R11: request held steady until the engine completes it
    a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)))
        else $error("a_r11_cmd_hold");

    // R11: a new command only follows a register access
    a_r11_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(reg_wr || reg_rd))
        else $error("a_r11_launch");

    // R6: a refused address or payload byte is followed by a stop
    a_r6_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done && cmd_nack && (cmd_op == 2'd0 || cmd_op == 2'd1))
        |=> (cmd_valid && cmd_op == 2'd3))
        else $error("a_r6_nack_stop");

    // R9: interrupt only rises after a completed command
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmd_valid && cmd_done))
        else $error("a_r9_irq_rise");

    // R10: interrupt only falls after a register write
    a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr))
        else $error("a_r10_irq_fall");

    // R12: divider output moves only after a register write
    a_r12_div_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr) |-> $stable(div_o))
        else $error("a_r12_div_stable");

endmodule

bind i2c_master_regfront i2c_rf_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_byte (cmd_byte),
    .cmd_done (cmd_done),
    .cmd_nack (cmd_nack),
    .irq      (irq),
    .div_o    (div_o)
);

// File: tb/i2c_master_regfront_tb_top.sv
`timescale 1ns/1ps
module i2c_master_regfront_tb_top;

    localparam int ADDR_W = 3;
    localparam int DIV_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_wr, reg_rd;
    logic [ADDR_W-1:0] reg_addr;
    logic [7:0]        reg_wdata, reg_rdata;
    logic              cmd_valid;
    logic [1:0]        cmd_op;
    logic [7:0]        cmd_byte;
    logic              cmd_done, cmd_nack;
    logic [7:0]        rx_byte;
    logic [DIV_W-1:0]  div_o;
    logic              irq;

    always #2 clk = ~clk;

    i2c_master_regfront #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .cmd_done(cmd_done), .cmd_nack(cmd_nack), .rx_byte(rx_byte),
        .div_o(div_o), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int eng_cnt = 0;
    int cmd_seen = 0;
    logic       nack_cfg = 1'b0;
    logic [7:0] rx_cfg = 8'h00;

    typedef struct {
        logic [1:0] op;
        logic [7:0] b;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_cmd(input logic [1:0] op, input logic [7:0] b, input string tag);
        exp_t e;
        e.op = op; e.b = b; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // bus engine model and scoreboard monitor
    initial begin
        cmd_done = 1'b0; cmd_nack = 1'b0; rx_byte = 8'h00;
        forever begin
            @(negedge clk);
            if (eng_cnt > 0) begin
                eng_cnt--;
                if (eng_cnt == 0) begin
                    cmd_done = 1'b1;
                    cmd_nack = nack_cfg;
                    rx_byte  = rx_cfg;
                end
            end else begin
                cmd_done = 1'b0;
                cmd_nack = 1'b0;
                if (cmd_valid && rst_n) begin
                    cmd_seen++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R11 unexpected command", int'(cmd_op), -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(cmd_op == e.op, {e.tag, " op"}, int'(cmd_op), int'(e.op));
                        if (e.op == 2'd0 || e.op == 2'd1)
                            check(cmd_byte == e.b, {e.tag, " byte"}, int'(cmd_byte), int'(e.b));
                    end
                    eng_cnt = 2;
                end
            end
        end
    end

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        rd(a, v);
        check(v == exp, tag, int'(v), int'(exp));
    endtask

    task automatic quiet();
        @(negedge clk); #1;
        while (cmd_valid || eng_cnt != 0 || cmd_done) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int seen0;
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // reset state
        check(irq == 1'b0 && cmd_valid == 1'b0, "R2 reset outputs", {irq, cmd_valid}, 0);
        rd_chk(2, 8'h00, "R2 reset control");
        rd_chk(3, 8'h00, "R2 reset status");
        rd_chk(4, 8'h00, "R2 reset data");

        // R1 masking and unmapped offsets
        wr(0, 8'hFF); rd_chk(0, 8'hFE, "R1 own address mask");
        wr(1, 8'hFF); rd_chk(1, 8'h3F, "R1 divider mask");
        check(div_o == 6'h3F, "R12 divider output", div_o, 6'h3F);
        wr(2, 8'h08); rd_chk(2, 8'h00, "R1 control mask");
        wr(5, 8'h55); rd_chk(5, 8'h00, "R1 unmapped read");
        rd_chk(1, 8'h3F, "R1 unmapped write harmless");

        // R7 data write ignored while disabled
        wr(2, 8'h20);
        rd_chk(3, 8'h20, "R3 busy set by master");
        seen0 = cmd_seen;
        wr(4, 8'hA0); quiet();
        check(cmd_seen == seen0, "R7 no command while disabled", cmd_seen - seen0, 0);

        // R5 address phase, R6 ack, R9 interrupt
        wr(2, 8'hF0);
        expect_cmd(2'd0, 8'hA4, "R5 start");
        wr(4, 8'hA4); quiet();
        rd_chk(3, 8'h22, "R6 ack clears nack and requests irq");
        check(irq == 1'b1, "R9 irq raised", irq, 1);

        // R10 flag clear semantics
        wr(3, 8'hFF); rd_chk(3, 8'h22, "R10 write one keeps flag");
        check(irq == 1'b1, "R10 irq kept", irq, 1);
        wr(3, 8'h00); rd_chk(3, 8'h20, "R10 write zero clears flag");
        check(irq == 1'b0, "R10 irq dropped", irq, 0);

        // R5 payload write, R11 second write while busy ignored
        expect_cmd(2'd1, 8'h5A, "R5 payload write");
        wr(4, 8'h5A); wr(4, 8'h77); quiet();
        rd_chk(3, 8'h22, "R6 payload ack");
        wr(3, 8'h00);

        // R6 payload nack closes the transfer
        nack_cfg = 1'b1;
        expect_cmd(2'd1, 8'h33, "R6 refused write");
        expect_cmd(2'd3, 8'h00, "R6 stop after nack");
        wr(4, 8'h33); quiet();
        nack_cfg = 1'b0;
        rd_chk(3, 8'h21, "R6 nack flag set");
        expect_cmd(2'd0, 8'h51, "R6 next write is address");
        wr(4, 8'h51); quiet();
        wr(3, 8'h00);

        // R8 receive pipeline
        wr(2, 8'hE0);
        rx_cfg = 8'h9C;
        expect_cmd(2'd2, 8'h00, "R8 read fetch");
        rd_chk(4, 8'h00, "R8 read returns held byte");
        quiet();
        check(irq == 1'b1, "R8 irq after fetch", irq, 1);
        wr(3, 8'h00);
        wr(2, 8'hF0);
        seen0 = cmd_seen;
        rd_chk(4, 8'h9C, "R8 fetched byte returned");
        rd_chk(4, 8'hFF, "R8 fill with transmit set");
        quiet();
        check(cmd_seen == seen0, "R8 no fetch with transmit set", cmd_seen - seen0, 0);

        // R4 repeated start
        expect_cmd(2'd3, 8'h00, "R4 stop on restart");
        wr(2, 8'hF4); quiet();
        rd_chk(2, 8'hF0, "R4 restart bit cleared");
        expect_cmd(2'd0, 8'h68, "R4 new address phase");
        wr(4, 8'h68); quiet();
        wr(3, 8'h00);

        // R3 master drop ends transfer
        expect_cmd(2'd3, 8'h00, "R3 stop on master clear");
        wr(2, 8'hD0); quiet();
        rd_chk(3, 8'h00, "R3 busy cleared");

        // R9 gating with interrupt enable off
        wr(2, 8'hB0);
        expect_cmd(2'd0, 8'h42, "R9 start without irq enable");
        wr(4, 8'h42); quiet();
        rd_chk(3, 8'h20, "R9 no flag without enable");
        check(irq == 1'b0, "R9 irq stays low", irq, 0);

        // R2 soft reset
        expect_cmd(2'd3, 8'h00, "R2 stop on soft reset");
        wr(2, 8'h30); quiet();
        rd_chk(2, 8'h00, "R2 control cleared");
        rd_chk(1, 8'h00, "R2 divider cleared");
        check(div_o == '0, "R12 divider output after reset", div_o, 0);
        rd_chk(0, 8'hFE, "R2 own address kept");
        rd_chk(4, 8'h00, "R2 held byte cleared");

        quiet();
        check(exp_q.size() == 0, "R11 all expected commands seen", exp_q.size(), 0);
        finish_run();
    end

endmodule